// File: doc/BRIEF.md
# Serial-Clock Reset Pattern Detector

This block watches the serial clock line of a serial port and turns a particular timing pattern on it into a chip reset. The pattern is three high pulses in a row. Each pulse must fall inside its own width window, and the three windows grow longer from the first pulse to the third. Each low gap between the pulses must last at least a minimum number of cycles. Every width is measured in cycles of the oscillator clock that runs the block. When the third pulse ends inside its window, the block issues a reset on that falling edge. The host can therefore reset the part over the serial lines alone, with no dedicated wire.

The serial clock is synchronized with two flops and then edge-detected. One saturating counter measures each high or low interval and restarts on every edge. A six-state machine follows the pattern through its states: `ST_IDLE` waits for a rising edge; `ST_HI1`, `ST_HI2` and `ST_HI3` measure the three high pulses; `ST_LO1` and `ST_LO2` measure the two gaps. The transitions are:

- idle-to-first: any accepted rising edge enters `ST_HI1`.
- pulse-accept: a falling edge whose width is inside the current window moves from `ST_HIk` to `ST_LOk`.
- gap-accept: a rising edge after a gap of at least the minimum moves from `ST_LOk` to `ST_HI(k+1)`.
- gap-short: a rising edge after a short gap restarts at `ST_HI1`.
- pulse-reject: a falling edge outside the window goes to `ST_LO1` if the pulse fits the first window, and to `ST_IDLE` otherwise.
- fire: a falling edge that ends a valid third pulse returns to `ST_IDLE` and issues the reset.
- abort: the machine is forced to `ST_IDLE` while the port is deselected, while a reset is being issued, or while the holdoff window that follows a reset is open.

The registered reset output is the OR of three sources: the pattern, a reset pin request and a reset command request. Every reset opens a holdoff window during which no serial clock edge is accepted.

Top module: `sclk_reset_detector`

## Requirements
- R1: Interval widths are counted in `clk` cycles of the level of `sclk_in`. The counter saturates at 2^CNT_W-1, so a longer interval is seen as exactly that width.
- R2: The first high pulse is accepted only if its width is in P1_MIN..P1_MAX inclusive (defaults 300..500).
- R3: The second high pulse is accepted only if its width is in P2_MIN..P2_MAX inclusive (defaults 550..750).
- R4: A third high pulse with width in P3_MIN..P3_MAX (defaults 1050..1250) sets `chip_rst` high for exactly one cycle. The rise happens on the second `clk` edge after the first edge that samples `sclk_in` low.
- R5: A low gap shorter than GAP_MIN cycles (default 5) breaks the pattern. The rising edge that ends the short gap is taken as the start of a new first pulse.
- R6: A high pulse outside its window returns the detector to idle. If that pulse lies inside the first window, it is taken as a new first pulse.
- R7: While `cs_n` is high the detector is held idle, and pulses seen while deselected do not count toward a pattern.
- R8: `chip_rst` is high in the cycle after every `clk` edge that samples `pin_rst_req` or `cmd_rst_req` high.
- R9: After each cycle with `chip_rst` high, `sclk_blocked` is high for HOLD cycles (default 16). Serial clock edges are ignored while it is high and during the reset cycle itself.
- R10: After `rst_n` the outputs are low and the detector is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial clock, asynchronous to `clk` |
| cs_n | input | 1 | Active-low port select, synchronous to `clk` |
| pin_rst_req | input | 1 | Reset request from the reset pin path |
| cmd_rst_req | input | 1 | Reset request from the command decoder |
| chip_rst | output | 1 | Registered chip reset pulse |
| sclk_blocked | output | 1 | High while serial clock edges are not accepted after a reset |

## Verification
The bench builds the block with windows scaled down tenfold: 30..50, 55..75 and 105..125. It keeps GAP_MIN at 5 and HOLD at 16 and narrows CNT_W to 8. With these values, every window edge, one cycle inside and one cycle outside, can be reached in a few hundred cycles. The 8-bit counter saturates at 255, so a third pulse of 300 cycles tests saturation. The full-width counter would need pulses of more than two thousand cycles for the same test.

// File: rtl/sclk_rst_pkg.sv
`timescale 1ns/1ps
package sclk_rst_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HI1  = 3'd1,
        ST_LO1  = 3'd2,
        ST_HI2  = 3'd3,
        ST_LO2  = 3'd4,
        ST_HI3  = 3'd5
    } det_state_t;
endpackage

// File: rtl/sclk_edge_sync.sv
`timescale 1ns/1ps
module sclk_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[SYNC_STAGES-1:0], sclk_in};
    end

    // pipe[SYNC_STAGES-1] is the synchronized level, pipe[SYNC_STAGES] the previous one
    always_comb begin
        rise = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];
        fall = ~pipe[SYNC_STAGES-1] & pipe[SYNC_STAGES];
    end
endmodule

// File: rtl/pulse_width_ctr.sv
`timescale 1ns/1ps
module pulse_width_ctr #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_seen,
    output logic [CNT_W-1:0] width
);
    localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            width <= '0;
        else if (edge_seen)    width <= {{(CNT_W-1){1'b0}}, 1'b1};
        else if (width != SAT) width <= width + 1'b1;
    end

    // R1: once saturated the count stays until the next edge
    a_r1_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (width == SAT && !edge_seen) |=> (width == SAT));
endmodule

// File: rtl/reset_holdoff.sv
`timescale 1ns/1ps
module reset_holdoff #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic blocked
);
    localparam int HW = $clog2(HOLD + 1);
    localparam logic [HW-1:0] HOLD_V = HW'(HOLD);

    logic [HW-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          left <= '0;
        else if (fire)       left <= HOLD_V;
        else if (left != '0) left <= left - 1'b1;
    end

    always_comb blocked = (left != '0);

    // R9: every reset cycle opens the holdoff window
    a_r9_blocked_follows: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> blocked);
endmodule

// File: rtl/det_fsm.sv
`timescale 1ns/1ps
module det_fsm
    import sclk_rst_pkg::*;
#(
    parameter int CNT_W   = 11,
    parameter int P1_MIN  = 300,
    parameter int P1_MAX  = 500,
    parameter int P2_MIN  = 550,
    parameter int P2_MAX  = 750,
    parameter int P3_MIN  = 1050,
    parameter int P3_MAX  = 1250,
    parameter int GAP_MIN = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             fall,
    input  logic [CNT_W-1:0] width,
    input  logic             abort,
    output det_state_t       state,
    output logic             hit
);
    det_state_t nxt;
    logic in_w1, in_w2, in_w3, gap_ok;

    always_comb begin
        in_w1  = (int'(width) >= P1_MIN) && (int'(width) <= P1_MAX);
        in_w2  = (int'(width) >= P2_MIN) && (int'(width) <= P2_MAX);
        in_w3  = (int'(width) >= P3_MIN) && (int'(width) <= P3_MAX);
        gap_ok = (int'(width) >= GAP_MIN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (abort) begin
            nxt = ST_IDLE;
        end else if (rise) begin
            unique case (state)
                ST_LO1:  nxt = gap_ok ? ST_HI2 : ST_HI1;
                ST_LO2:  nxt = gap_ok ? ST_HI3 : ST_HI1;
                default: nxt = ST_HI1;
            endcase
        end else if (fall) begin
            unique case (state)
                ST_HI1:  nxt = in_w1 ? ST_LO1 : ST_IDLE;
                ST_HI2:  nxt = in_w2 ? ST_LO2 : (in_w1 ? ST_LO1 : ST_IDLE);
                ST_HI3:  nxt = (!in_w3 && in_w1) ? ST_LO1 : ST_IDLE;
                default: nxt = state;
            endcase
        end
    end

    always_comb hit = !abort && fall && (state == ST_HI3) && in_w3;

    // R7: abort always lands in idle
    a_r7_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state == ST_IDLE));
    // R5: the third pulse is reached only through the second gap
    a_r5_hi3_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HI3 && $past(state) != ST_HI3) |-> ($past(state) == ST_LO2));
endmodule

// File: rtl/sclk_reset_detector.sv
`timescale 1ns/1ps
module sclk_reset_detector
    import sclk_rst_pkg::*;
#(
    parameter int CNT_W   = 11,
    parameter int P1_MIN  = 300,
    parameter int P1_MAX  = 500,
    parameter int P2_MIN  = 550,
    parameter int P2_MAX  = 750,
    parameter int P3_MIN  = 1050,
    parameter int P3_MAX  = 1250,
    parameter int GAP_MIN = 5,
    parameter int HOLD    = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic cs_n,
    input  logic pin_rst_req,
    input  logic cmd_rst_req,
    output logic chip_rst,
    output logic sclk_blocked
);
    logic             rise, fall, hit, abort;
    logic [CNT_W-1:0] width;
    det_state_t       state;

    sclk_edge_sync #(.SYNC_STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .rise(rise), .fall(fall)
    );

    pulse_width_ctr #(.CNT_W(CNT_W)) u_width (
        .clk(clk), .rst_n(rst_n), .edge_seen(rise | fall), .width(width)
    );

    always_comb abort = cs_n | chip_rst | sclk_blocked;

    det_fsm #(
        .CNT_W(CNT_W), .P1_MIN(P1_MIN), .P1_MAX(P1_MAX), .P2_MIN(P2_MIN),
        .P2_MAX(P2_MAX), .P3_MIN(P3_MIN), .P3_MAX(P3_MAX), .GAP_MIN(GAP_MIN)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .width(width),
        .abort(abort), .state(state), .hit(hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chip_rst <= 1'b0;
        else        chip_rst <= hit | pin_rst_req | cmd_rst_req;
    end

    reset_holdoff #(.HOLD(HOLD)) u_hold (
        .clk(clk), .rst_n(rst_n), .fire(chip_rst), .blocked(sclk_blocked)
    );

    // R4: a pattern-only reset lasts one cycle
    a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_rst && !pin_rst_req && !cmd_rst_req) |=> !chip_rst);
    // R8: pin and command requests reach the output
    a_r8_request_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_rst_req || cmd_rst_req) |=> chip_rst);
    // R9: detector stays idle while edges are blocked
    a_r9_idle_while_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_blocked |-> (state == ST_IDLE));
endmodule

// File: tb/sclk_reset_detector_bench.sv
`timescale 1ns/1ps
module sclk_reset_detector_bench;
    localparam int W1L = 30, W1H = 50, W2L = 55, W2H = 75, W3L = 105, W3H = 125;
    localparam int GAP = 5, HOLDC = 16, CW = 8, SATV = 255;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk_in = 1'b0, cs_n = 1'b0, pin_rst_req = 1'b0, cmd_rst_req = 1'b0;
    logic chip_rst, sclk_blocked;

    int checks = 0, failures = 0;
    int rst_cycles = 0, blk_cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sclk_reset_detector #(
        .CNT_W(CW), .P1_MIN(W1L), .P1_MAX(W1H), .P2_MIN(W2L), .P2_MAX(W2H),
        .P3_MIN(W3L), .P3_MAX(W3H), .GAP_MIN(GAP), .HOLD(HOLDC)
    ) u_sclk_reset_detector (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .cs_n(cs_n),
        .pin_rst_req(pin_rst_req), .cmd_rst_req(cmd_rst_req),
        .chip_rst(chip_rst), .sclk_blocked(sclk_blocked)
    );

    // behavioural reference: stage 0 idle, 1/3/5 high pulses, 2/4 gaps
    bit hist[$];
    int m_stage = 0, m_run = 0, m_blk = 0;
    bit m_rst = 0;
    bit cur, prv, up, dn, ab, mhit;
    int w;

    function automatic bit inside_w(int v, int lo, int hi);
        return (v >= lo) && (v <= hi);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            m_stage = 0; m_run = 0; m_blk = 0; m_rst = 0;
        end else begin
            hist.push_back(sclk_in);
            if (hist.size() > 4) void'(hist.pop_front());
            cur = (hist.size() >= 3) ? hist[hist.size()-3] : 1'b0;
            prv = (hist.size() >= 4) ? hist[hist.size()-4] : 1'b0;
            up = cur && !prv;
            dn = !cur && prv;
            w = m_run;
            ab = cs_n || m_rst || (m_blk > 0);
            mhit = 0;
            if (ab) m_stage = 0;
            else if (up) begin
                if (m_stage == 2 && w >= GAP) m_stage = 3;
                else if (m_stage == 4 && w >= GAP) m_stage = 5;
                else m_stage = 1;
            end else if (dn) begin
                if (m_stage == 5 && inside_w(w, W3L, W3H)) begin mhit = 1; m_stage = 0; end
                else if (m_stage == 3 && inside_w(w, W2L, W2H)) m_stage = 4;
                else if (m_stage == 1 || m_stage == 3 || m_stage == 5)
                    m_stage = inside_w(w, W1L, W1H) ? 2 : 0;
            end
            if (m_rst) m_blk = HOLDC;
            else if (m_blk > 0) m_blk = m_blk - 1;
            m_rst = mhit || pin_rst_req || cmd_rst_req;
            if (up || dn) m_run = 1;
            else if (m_run < SATV) m_run = m_run + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (chip_rst !== m_rst) begin
                failures++;
                $display("FAIL R4 chip_rst per-cycle: actual=%0b expected=%0b t=%0t", chip_rst, m_rst, $time);
            end
            checks++;
            if (sclk_blocked !== (m_blk > 0)) begin
                failures++;
                $display("FAIL R9 sclk_blocked per-cycle: actual=%0b expected=%0b t=%0t", sclk_blocked, (m_blk > 0), $time);
            end
            if (chip_rst) rst_cycles++;
            if (sclk_blocked) blk_cycles++;
        end
    end

    task automatic hi(int n);
        sclk_in = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic lo(int n);
        sclk_in = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_count(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic three(int a, int g1, int b, int g2, int c);
        hi(a); lo(g1); hi(b); lo(g2); hi(c); lo(40);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        checks++;
        if (chip_rst !== 1'b0 || sclk_blocked !== 1'b0) begin
            failures++;
            $display("FAIL R10 reset state: actual=%0b%0b expected=00", chip_rst, sclk_blocked);
        end
        rst_n = 1'b1;
        lo(10);

        rst_cycles = 0; three(40, 10, 65, 10, 115);
        expect_count("R4 nominal pattern", rst_cycles, 1);
        expect_count("R9 holdoff length", blk_cycles, HOLDC);

        rst_cycles = 0; three(W1L, GAP, W2L, GAP, W3L);
        expect_count("R2 R3 R4 lower bounds", rst_cycles, 1);
        rst_cycles = 0; three(W1H, GAP, W2H, GAP, W3H);
        expect_count("R2 R3 R4 upper bounds", rst_cycles, 1);

        rst_cycles = 0; three(W1L - 1, 10, 65, 10, 115);
        expect_count("R2 first too short", rst_cycles, 0);
        rst_cycles = 0; three(W1H + 1, 10, 65, 10, 115);
        expect_count("R2 first too long", rst_cycles, 0);
        rst_cycles = 0; three(40, 10, W2H + 1, 10, 115);
        expect_count("R3 second too long", rst_cycles, 0);
        rst_cycles = 0; three(40, 10, W2L - 1, 10, 115);
        expect_count("R3 second too short", rst_cycles, 0);
        rst_cycles = 0; three(40, 10, 65, 10, W3H + 1);
        expect_count("R4 third too long", rst_cycles, 0);
        rst_cycles = 0; three(40, 10, 65, 10, W3L - 1);
        expect_count("R4 third too short", rst_cycles, 0);
        rst_cycles = 0; three(40, 10, 65, 10, 300);
        expect_count("R1 saturated third", rst_cycles, 0);

        rst_cycles = 0; three(40, GAP - 1, 65, 10, 115);
        expect_count("R5 short gap", rst_cycles, 0);
        rst_cycles = 0; hi(40); lo(GAP - 1); three(40, 10, 65, 10, 115);
        expect_count("R5 short gap restarts first", rst_cycles, 1);

        rst_cycles = 0; hi(40); lo(10); three(45, 10, 65, 10, 115);
        expect_count("R6 rejected second reused as first", rst_cycles, 1);

        rst_cycles = 0; hi(40); lo(5); cs_n = 1'b1; lo(4); cs_n = 1'b0; lo(3);
        hi(65); lo(10); hi(115); lo(40);
        expect_count("R7 deselect mid pattern", rst_cycles, 0);
        rst_cycles = 0; cs_n = 1'b1; three(40, 10, 65, 10, 115); cs_n = 1'b0;
        expect_count("R7 pattern while deselected", rst_cycles, 0);

        rst_cycles = 0; blk_cycles = 0;
        pin_rst_req = 1'b1; @(negedge clk); pin_rst_req = 1'b0; lo(30);
        expect_count("R8 pin request", rst_cycles, 1);
        expect_count("R9 pin holdoff", blk_cycles, HOLDC);
        rst_cycles = 0;
        cmd_rst_req = 1'b1; @(negedge clk); cmd_rst_req = 1'b0; lo(30);
        expect_count("R8 command request", rst_cycles, 1);

        rst_cycles = 0;
        pin_rst_req = 1'b1; @(negedge clk); pin_rst_req = 1'b0;
        three(40, 10, 65, 10, 115);
        expect_count("R9 edges ignored in holdoff", rst_cycles, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #750000;
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule